// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block connects a single-beat request port inside a synchronous design to an external asynchronous static RAM of 1M words by 16 bits. A user asserts a request together with a direction bit, a 20-bit word address, 16 bits of write data and two byte enables. The sequencer then drives the memory's address, an active-low select and an active-high select, the output and write strobes, the two byte-lane strobes and a shared bidirectional data bus. Each phase lasts a whole number of clock cycles, so the memory's minimum access, pulse and setup times are always met.

Each phase length is derived at elaboration time from nanosecond limits and the clock period, always rounding up. Reads hold the output strobe low for the full access window and capture the data on the last cycle, before the strobe is released. Writes keep the output strobe high throughout. The data bus is turned on only after the write strobe has fallen. A write ends on the rising edge of the write strobe, and the address, selects and data are held for one more cycle after that edge. A one-cycle done pulse closes every access.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset, the active-low select, the write strobe, the output strobe and both byte-lane strobes are high, the active-high select is low, busy and done are low, and the data bus is not driven.
- R2: A read drives the active-low select low, the active-high select high, the write strobe high and the output strobe low, with the addressed word on the address pins, for RD_CYC cycles (3 at a 10 ns clock).
- R3: Read data is returned with each lane gated by its enable. Lane 0 is bits 7:0 and lane 1 is bits 15:8. A disabled lane reads as zero.
- R4: During a write the output strobe stays high. The write strobe is low for exactly WLO_CYC consecutive cycles (3 by default: at least one idle cycle plus the data setup, and at least the pulse width).
- R5: In the cycle after the write strobe rises, the selects, address and write data are still presented on the memory pins. The data bus is released when that cycle ends.
- R6: Enable bit 0 pulls the lower-lane strobe low and enable bit 1 pulls the upper-lane strobe low. A write with one enable leaves the other byte of the stored word unchanged.
- R7: busy is high from the cycle after a request is accepted until done. done is a single-cycle pulse, and busy is low in that same cycle.
- R8: A request made while busy is ignored. The address on the pins does not change, and no write is performed.
- R9: done appears RD_CYC clock edges after the accepting edge for a read, and WLO_CYC+HOLD_CYC edges after it for a write (3 and 4 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, taken only when not busy |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_ben | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with done |
| mem_addr | output | AW | Memory address pins |
| mem_cs_n | output | 1 | Active-low select |
| mem_cs2 | output | 1 | Active-high select |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ub_n | output | 1 | Upper-lane strobe, active low |
| mem_lb_n | output | 1 | Lower-lane strobe, active low |
| mem_dq | inout | 16 | Bidirectional data bus |

## Verification
If the phase counter is loaded with the wrong value, done arrives on the wrong edge, and a latency check catches it on the first access of either kind. A wrong state transition shows up in the same access, either as the output strobe going low during a write or as the write strobe pulse having the wrong length. Faults in the lane strobes or the read mask surface at the next read-back of a partially written word. A busy guard that lets a second request through changes the address pins within one cycle, which the bench samples directly.

// File: rtl/sram_async_ctl.sv
module sram_async_ctl #(
  parameter int AW        = 20,
  parameter int CLK_NS    = 10,
  parameter int T_RC_NS   = 25,
  parameter int T_AA_NS   = 25,
  parameter int T_DOE_NS  = 12,
  parameter int T_PWE_NS  = 18,
  parameter int T_AW_NS   = 15,
  parameter int T_SD_NS   = 12,
  parameter int HOLD_CYC  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_ben,
  output logic          busy,
  output logic          done,
  output logic [15:0]   rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_cs2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  inout  wire  [15:0]   mem_dq
);

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC  = max2(max2(cdiv(T_RC_NS, CLK_NS), cdiv(T_AA_NS, CLK_NS)),
                                max2(cdiv(T_DOE_NS, CLK_NS), 1));
  localparam int WLO_CYC = max2(max2(cdiv(T_PWE_NS, CLK_NS), cdiv(T_AW_NS, CLK_NS)),
                                cdiv(T_SD_NS, CLK_NS) + 1);
  localparam int CW      = $clog2(max2(max2(RD_CYC, WLO_CYC), HOLD_CYC) + 1) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WLO, ST_WHLD} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [15:0]   wd_q;
  logic          dq_en;

  assign busy     = (state != ST_IDLE);
  assign mem_addr = addr_q;
  assign mem_dq   = dq_en ? wd_q : 16'bz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      addr_q   <= '0;
      wd_q     <= '0;
      dq_en    <= 1'b0;
      done     <= 1'b0;
      rdata    <= '0;
      mem_cs_n <= 1'b1;
      mem_cs2  <= 1'b0;
      mem_oe_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_ub_n <= 1'b1;
      mem_lb_n <= 1'b1;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (req) begin
          addr_q   <= req_addr;
          wd_q     <= req_wdata;
          mem_cs_n <= 1'b0;
          mem_cs2  <= 1'b1;
          mem_lb_n <= ~req_ben[0];
          mem_ub_n <= ~req_ben[1];
          if (req_wr) begin
            mem_we_n <= 1'b0;
            cnt      <= CW'(WLO_CYC - 1);
            state    <= ST_WLO;
          end else begin
            mem_oe_n <= 1'b0;
            cnt      <= CW'(RD_CYC - 1);
            state    <= ST_RD;
          end
        end
        ST_RD: if (cnt == '0) begin
          rdata    <= mem_dq & {{8{~mem_ub_n}}, {8{~mem_lb_n}}};
          mem_oe_n <= 1'b1;
          mem_cs_n <= 1'b1;
          mem_cs2  <= 1'b0;
          mem_ub_n <= 1'b1;
          mem_lb_n <= 1'b1;
          done     <= 1'b1;
          state    <= ST_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_WLO: begin
          dq_en <= 1'b1;
          if (cnt == '0) begin
            mem_we_n <= 1'b1;
            cnt      <= CW'(HOLD_CYC - 1);
            state    <= ST_WHLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WHLD: if (cnt == '0) begin
          dq_en    <= 1'b0;
          mem_cs_n <= 1'b1;
          mem_cs2  <= 1'b0;
          mem_ub_n <= 1'b1;
          mem_lb_n <= 1'b1;
          done     <= 1'b1;
          state    <= ST_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic [CW-1:0] wl_len;
  always_ff @(posedge clk) begin
    if (!rst_n)         wl_len <= '0;
    else if (!mem_we_n) wl_len <= wl_len + 1'b1;
    else                wl_len <= '0;
  end

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_cs_n && !mem_cs2 && mem_we_n && mem_oe_n && !dq_en));

  p_oe_we_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  p_we_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wl_len == CW'(WLO_CYC)));

  p_drive_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_en |-> (!mem_cs_n && mem_cs2 && mem_oe_n));

  p_we_rise_driven_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (dq_en && !mem_cs_n));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr));

endmodule

// File: tb/tb_sram_async_ctl.sv
module tb_sram_async_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_wr = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_ben = '0;
  logic        busy, done;
  logic [15:0] rdata;
  logic [19:0] mem_addr;
  logic        mem_cs_n, mem_cs2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
  wire  [15:0] mem_dq;

  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  sram_async_ctl dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ben(req_ben), .busy(busy), .done(done), .rdata(rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq(mem_dq));

  logic [15:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = '0;

  assign mem_dq = (!mem_cs_n && mem_cs2 && !mem_oe_n && mem_we_n) ? mem[mem_addr[7:0]] : 16'bz;

  always @(posedge mem_we_n) begin
    if (rst_n && !mem_cs_n && mem_cs2) begin
      if (!mem_lb_n) mem[mem_addr[7:0]][7:0]  = mem_dq[7:0];
      if (!mem_ub_n) mem[mem_addr[7:0]][15:8] = mem_dq[15:8];
    end
  end

  int  wl_run = 0, wl_last = 0;
  bit  oe_in_wr = 0;
  always @(negedge clk) begin
    if (!mem_we_n) begin
      wl_run++;
      if (!mem_oe_n) oe_in_wr = 1;
    end else if (wl_run != 0) begin
      wl_last = wl_run;
      wl_run  = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic wr, input logic [19:0] a, input logic [15:0] d,
                    input logic [1:0] be, output logic [15:0] rd, output int lat);
    @(negedge clk);
    req = 1; req_wr = wr; req_addr = a; req_wdata = d; req_ben = be;
    @(posedge clk);
    @(negedge clk);
    req = 0;
    check(busy == 1'b1, "R7 busy", busy, 1);
    check({mem_cs_n, mem_cs2, mem_lb_n, mem_ub_n} == {1'b0, 1'b1, ~be[0], ~be[1]},
          "R6 selects/strobes", {mem_cs_n, mem_cs2, mem_lb_n, mem_ub_n},
          {1'b0, 1'b1, ~be[0], ~be[1]});
    if (!wr) check(!mem_oe_n && mem_we_n && mem_addr == a, "R2 read pins", mem_addr, a);
    lat = 0;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
      if (wr && lat == 3)
        check(mem_we_n && !mem_cs_n && mem_dq == d && mem_addr == a, "R5 hold",
              mem_dq, d);
    end
    check(!busy, "R7 busy low at done", busy, 0);
    rd = rdata;
    @(negedge clk);
    check(!done, "R7 done pulse", done, 0);
  endtask

  localparam logic [54:0] VEC [8] = '{
    {1'b1, 20'h00010, 16'hA5C3, 2'b11, 16'h0000},
    {1'b1, 20'h00020, 16'h1234, 2'b11, 16'h0000},
    {1'b0, 20'h00010, 16'h0000, 2'b11, 16'hA5C3},
    {1'b1, 20'h00010, 16'hFF77, 2'b01, 16'h0000},
    {1'b0, 20'h00010, 16'h0000, 2'b11, 16'hA577},
    {1'b1, 20'h00020, 16'hBEEF, 2'b10, 16'h0000},
    {1'b0, 20'h00020, 16'h0000, 2'b10, 16'hBE00},
    {1'b0, 20'h00020, 16'h0000, 2'b01, 16'h0034}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL R7 watchdog actual=%0d expected=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({mem_cs_n, mem_cs2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, busy, done} ==
          8'b10111100, "R1 reset pins",
          {mem_cs_n, mem_cs2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, busy, done}, 8'hBC);

    for (int i = 0; i < 8; i++) begin
      logic [54:0] v;
      v = VEC[i];
      oe_in_wr = 0;
      op(v[54], v[53:34], v[33:18], v[17:16], rd, lat);
      if (v[54]) begin
        check(lat == 4, "R9 write latency", lat, 4);
        check(wl_last == 3, "R4 write strobe width", wl_last, 3);
        check(!oe_in_wr, "R4 output strobe high in write", oe_in_wr, 0);
      end else begin
        check(lat == 3, "R9 read latency", lat, 3);
        check(rd == v[15:0], "R3 R6 read data", rd, v[15:0]);
      end
    end

    // R8: write request during a busy read is ignored
    @(negedge clk);
    req = 1; req_wr = 0; req_addr = 20'h00010; req_ben = 2'b11;
    @(posedge clk);
    @(negedge clk);
    req = 1; req_wr = 1; req_addr = 20'h00030; req_wdata = 16'h9999;
    @(negedge clk);
    req = 0;
    check(mem_addr == 20'h00010 && mem_we_n, "R8 address held", mem_addr, 20'h10);
    while (!done) @(negedge clk);
    check(rdata == 16'hA577, "R8 read during ignored req", rdata, 16'hA577);
    repeat (2) @(negedge clk);
    op(1'b0, 20'h00030, 16'h0, 2'b11, rd, lat);
    check(rd == 16'h0000, "R8 no write performed", rd, 0);
    check(lat == 3, "R2 read window", lat, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule